// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides a double-width dividend by a single-width divisor over several clock cycles. It returns a single-width quotient and a single-width remainder. A request is made by pulsing `start` while the block is idle. The operands and a signed/unsigned selector are sampled on that edge. In each later cycle the block works out one quotient bit. It shifts the partial remainder left, tries a subtraction of the divisor and keeps the difference only when it does not go negative. The shift comes from how the register input is wired, so no cycle is spent on it. The quotient bits fill the bottom of the same accumulator as it shifts, so there is no separate quotient register.

In signed mode the operands are turned into magnitudes before the divide starts. The unsigned result is corrected afterwards. The quotient sign is the XOR of the operand signs, and the remainder takes the sign of the dividend. A zero divisor, or a quotient too large for the result width, is detected on the accepting edge. In those cases no iterations run and the error flag is reported at once.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `overflow`, `quotient` and `remainder` are all zero.
- R2: In unsigned mode (`is_signed`=0) with a nonzero divisor greater than the upper K dividend bits, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor.
- R3: For a divide that runs, `done` is high for exactly one cycle, K rising edges after the edge that accepts `start`. `busy` is high in between and low while `done` is high.
- R4: A zero divisor produces `done` directly after the accepting edge, with `div_zero`=1, `overflow`=0, `quotient`=0 and `remainder`=0.
- R5: With a nonzero divisor whose magnitude is not greater than the magnitude of the upper K dividend bits, `done` follows the accepting edge directly, with `overflow`=1, `div_zero`=0 and both results zero.
- R6: With `is_signed`=1 both operands are two's complement. The quotient is truncated toward zero and is negative when the operand signs differ. The remainder carries the dividend's sign. Overflow (R5) is judged on the magnitudes.
- R7: A `start` pulse while `busy` is high is ignored, and the running divide completes with its own result.
- R8: Once `done` has pulsed, `quotient`, `remainder` and the flags hold their values until the next accepted `start`.
- R9: A K-bit dividend zero-extended into the upper half never overflows for any nonzero divisor, and gives the exact K/K quotient and remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a divide; taken only while idle |
| is_signed | input | 1 | 1 = two's complement operands |
| dividend | input | 2K | Dividend |
| divisor | input | K | Divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle result-ready pulse |
| quotient | output | K | Quotient |
| remainder | output | K | Remainder |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient would not fit in K bits |

## Verification
Two events can land in the same cycle: the completion pulse of one divide and the acceptance of the next `start`. The driver issues each new request at the first idle cycle, which is the very cycle in which `done` is high. The monitor checks the finishing result in that cycle and times the new request's latency from that edge. A start pulse during a running divide, with a zero divisor, checks that the running result is the one that comes out.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
    parameter int K = 8
) (
    input  logic             is_signed,
    input  logic [2*K-1:0]   dividend,
    input  logic [K-1:0]     divisor,
    output logic [2*K-1:0]   mag_dvd,
    output logic [K-1:0]     mag_dvs,
    output logic             neg_q,
    output logic             neg_r,
    output logic             dz,
    output logic             ovf
);
    localparam int DW = 2 * K;

    logic sgn_dvd, sgn_dvs;

    always_comb begin
        sgn_dvd = is_signed & dividend[DW-1];
        sgn_dvs = is_signed & divisor[K-1];
        mag_dvd = sgn_dvd ? (~dividend + DW'(1)) : dividend;
        mag_dvs = sgn_dvs ? (~divisor + K'(1)) : divisor;
        neg_q   = sgn_dvd ^ sgn_dvs;
        neg_r   = sgn_dvd;
        dz      = (divisor == '0);
        ovf     = !dz && (mag_dvd[DW-1:K] >= mag_dvs);
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int K = 8
) (
    input  logic [2*K-1:0] acc,
    input  logic [K-1:0]   dvs,
    output logic [2*K-1:0] acc_nxt
);
    localparam int DW = 2 * K;

    logic [K:0]   shifted_top;
    logic [K:0]   trial;
    logic         fits;
    logic [K-1:0] new_top;

    always_comb begin
        shifted_top = acc[DW-1:K-1];
        trial       = shifted_top - {1'b0, dvs};
        fits        = (shifted_top >= {1'b0, dvs});
        new_top     = fits ? trial[K-1:0] : shifted_top[K-1:0];
        acc_nxt     = {new_top, acc[K-2:0], fits};
    end
endmodule

// File: rtl/div_fixup.sv
module div_fixup #(
    parameter int W = 8
) (
    input  logic [W-1:0] mag,
    input  logic         neg,
    output logic [W-1:0] value
);
    always_comb begin
        value = neg ? (~mag + W'(1)) : mag;
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int K = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [2*K-1:0]   dividend,
    input  logic [K-1:0]     divisor,
    output logic             busy,
    output logic             done,
    output logic [K-1:0]     quotient,
    output logic [K-1:0]     remainder,
    output logic             div_zero,
    output logic             overflow
);
    localparam int DW = 2 * K;
    localparam int CW = (K > 1) ? $clog2(K) : 1;

    typedef struct packed {
        phase_e          phase;
        logic            done;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   acc;
        logic [K-1:0]    dvs;
        logic            neg_q;
        logic            neg_r;
        logic            dz;
        logic            ovf;
    } state_t;

    state_t s_d, s_q;

    logic [DW-1:0] p_mag_dvd;
    logic [K-1:0]  p_mag_dvs;
    logic          p_neg_q, p_neg_r, p_dz, p_ovf;
    logic [DW-1:0] step_acc;

    div_prep #(.K(K)) u_prep (
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .mag_dvd   (p_mag_dvd),
        .mag_dvs   (p_mag_dvs),
        .neg_q     (p_neg_q),
        .neg_r     (p_neg_r),
        .dz        (p_dz),
        .ovf       (p_ovf)
    );

    div_step #(.K(K)) u_step (
        .acc     (s_q.acc),
        .dvs     (s_q.dvs),
        .acc_nxt (step_acc)
    );

    div_fixup #(.W(K)) u_fix_q (
        .mag   (s_q.acc[K-1:0]),
        .neg   (s_q.neg_q),
        .value (quotient)
    );

    div_fixup #(.W(K)) u_fix_r (
        .mag   (s_q.acc[DW-1:K]),
        .neg   (s_q.neg_r),
        .value (remainder)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.dz  = p_dz;
                    s_d.ovf = p_ovf;
                    if (p_dz || p_ovf) begin
                        s_d.acc   = '0;
                        s_d.neg_q = 1'b0;
                        s_d.neg_r = 1'b0;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_RUN;
                        s_d.cnt   = CW'(K - 1);
                        s_d.acc   = p_mag_dvd;
                        s_d.dvs   = p_mag_dvs;
                        s_d.neg_q = p_neg_q;
                        s_d.neg_r = p_neg_r;
                    end
                end
            end
            PH_RUN: begin
                s_d.acc = step_acc;
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.phase == PH_RUN);
    assign done     = s_q.done;
    assign div_zero = s_q.dz;
    assign overflow = s_q.ovf;

    // R4: a zero divisor is never reported as an overflow as well
    p_dz_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> !overflow);

    // R3: the completion pulse lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

    // R3: no completion while iterations are still running
    p_busy_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R5: error exits leave both results at zero
    p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_zero || overflow) |-> (quotient == '0 && remainder == '0));

    // R7: a running divide carries on regardless of start
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> (busy || done));

    // R8: results hold while idle and no request arrives
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> ($stable(quotient) && $stable(remainder)
                             && $stable(div_zero) && $stable(overflow)));
endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb;
    localparam int K  = 8;
    localparam int DW = 2 * K;

    typedef struct {
        logic [K-1:0] q;
        logic [K-1:0] r;
        logic         dz;
        logic         ovf;
        int           lat;
        int           acc_cyc;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          is_signed = 1'b0;
    logic [DW-1:0] dividend = '0;
    logic [K-1:0]  divisor = '0;
    logic          busy, done, div_zero, overflow;
    logic [K-1:0]  quotient, remainder;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seq_divider #(.K(K)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero),
        .overflow  (overflow)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic sgn, input logic [DW-1:0] dvd,
                                   input logic [K-1:0] dvs, input string tag);
        exp_t e;
        longint unsigned md, mv, qq, rr;
        logic sd, sv;
        e.tag = tag; e.dz = 0; e.ovf = 0; e.q = '0; e.r = '0; e.lat = 0; e.acc_cyc = 0;
        sd = sgn & dvd[DW-1];
        sv = sgn & dvs[K-1];
        md = sd ? ((64'd1 << DW) - dvd) : dvd;
        mv = sv ? ((64'd1 << K) - dvs) : dvs;
        if (dvs == '0) begin
            e.dz = 1;
        end else if ((md >> K) >= mv) begin
            e.ovf = 1;
        end else begin
            qq = md / mv;
            rr = md % mv;
            e.q = (sd ^ sv) ? K'((64'd1 << K) - qq) : K'(qq);
            e.r = sd ? K'((64'd1 << K) - rr) : K'(rr);
            e.lat = K;
        end
        return e;
    endfunction

    task automatic issue(input logic sgn, input logic [DW-1:0] dvd,
                         input logic [K-1:0] dvs, input string tag);
        exp_t e;
        while (busy) @(negedge clk);
        e = model(sgn, dvd, dvs, tag);
        is_signed = sgn; dividend = dvd; divisor = dvs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e.acc_cyc = cyc;
        sb.push_back(e);
    endtask

    // Monitor: compares every completion with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R3: unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " quotient"}, quotient, e.q);
                check({e.tag, " remainder"}, remainder, e.r);
                check({e.tag, " div_zero R4"}, div_zero, e.dz);
                check({e.tag, " overflow R5"}, overflow, e.ovf);
                check({e.tag, " latency R3"}, cyc - e.acc_cyc, e.lat);
                check("busy low at done R3", busy, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 div_zero", div_zero, 0);
        check("R1 overflow", overflow, 0);
        check("R1 quotient", quotient, 0);
        check("R1 remainder", remainder, 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(1'b0, 16'd1000, 8'd7, "R2 1000/7");
        // R8: result holds after completion
        while (busy || done) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R8 held quotient", quotient, 142);
        check("R8 held remainder", remainder, 6);

        issue(1'b0, 16'h7FFF, 8'h80, "R2 max fit");
        issue(1'b0, 16'h00FF, 8'd1, "R9 255/1");
        issue(1'b0, 16'h00FF, 8'hFF, "R9 255/255");
        issue(1'b0, 16'h0003, 8'hFE, "R9 small/large");
        issue(1'b0, 16'h0100, 8'd1, "R5 unsigned ovf");
        issue(1'b0, 16'h1234, 8'h00, "R4 zero divisor");
        issue(1'b1, 16'hFF9C, 8'd7, "R6 -100/7");
        issue(1'b1, 16'd100, 8'hF9, "R6 100/-7");
        issue(1'b1, 16'hFF9C, 8'hF9, "R6 -100/-7");
        issue(1'b1, 16'h8000, 8'h80, "R6 ovf magnitude");
        issue(1'b1, 16'hFF00, 8'd0, "R4 signed zero");

        // R7: start while busy is ignored
        issue(1'b0, 16'd5000, 8'd77, "R7 running divide");
        @(negedge clk);
        check("R7 busy mid-run", busy, 1);
        is_signed = 1'b0; dividend = 16'h0001; divisor = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        for (int i = 0; i < 60; i++) begin
            logic [DW-1:0] d;
            logic [K-1:0]  v;
            logic          s;
            d = DW'($urandom);
            v = K'($urandom);
            s = 1'($urandom);
            if (i % 3 == 0) d[DW-1:K] = '0;
            issue(s, d, v, s ? "R6 random" : "R2 random");
        end

        while (busy || sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", sb.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule